// File: doc/BRIEF.md
# Serial Command Decoder for a Two-Channel 8-bit DAC

This block is the digital front end of a two-channel 8-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. Each word carries a two-bit target code, a speed flag, a power-down flag and a payload. The block decodes the word and updates the channel A code, the channel B code, a holding register or the reference-select field.

The holding register lets the host stage a value for channel B. A later channel A write then moves the staged value into channel B on the same clock edge, so both outputs change together. All serial pins are brought into the system clock domain through synchronisers, and edges are detected there. The system clock must run at least four times faster than the serial clock.

For every target that a command writes, the block raises a one-cycle strobe. The strobe is high in the same cycle that the new value first appears on the output.

Top module: `dual_dac_cmd_dec`

## Requirements
- R1: A falling edge of the select line starts a frame. While select is low, each falling serial-clock edge shifts one data bit in, most significant bit first.
- R2: When the 16th bit has been shifted in, the word is committed. The outputs and strobes change a few system cycles later, while select is still low.
- R3: If select rises after k bits, where 0 < k < 16, the k received bits are committed as the low k bits of a word whose upper bits are zero. If select rises with no bits received, nothing is committed.
- R4: The target code is {bit 15, bit 12}, and each value writes as follows:
  - 00 writes the payload to channel B and to the holding register.
  - 01 writes the payload to the holding register only.
  - 10 writes the payload to channel A and, on the same edge, copies the old holding register into channel B.
  - 11 writes the control field.
- R5: For the three data targets, the payload is bits 11:4. Bits 3:0 have no effect on any output.
- R6: For a control write, refSel takes bits 1:0, with 00 external, 01 internal low, 10 internal high and 11 external. Bits 11:2 are ignored, and the channel codes and the holding register keep their values.
- R7: Every committed word updates fastMode from bit 14 (1 = fast) and powerDown from bit 13 (1 = powered down), whatever its target code.
- R8: Each frame commits at most once. Serial-clock edges after the 16th bit, while select is still low, change nothing.
- R9: Reset clears both channel codes, the holding register, fastMode, powerDown, refSel and all strobes to zero.
- R10: The strobes updA, updB, updBuf and updCtl each pulse for one cycle for every target a commit writes. A strobe is high in the first cycle in which that output shows its new value. Outside such a pulse, the corresponding output does not change.
- R11: Serial-clock edges while select is high shift nothing and commit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock; data sampled on its falling edge |
| serSelN | input | 1 | Active-low frame select |
| serData | input | 1 | Serial data, MSB first |
| chanA | output | 8 | Channel A output code |
| chanB | output | 8 | Channel B output code |
| holdBuf | output | 8 | Staged value for channel B |
| fastMode | output | 1 | 1 = fast settling mode |
| powerDown | output | 1 | 1 = powered down |
| refSel | output | 2 | Reference source select |
| updA | output | 1 | Channel A written this cycle |
| updB | output | 1 | Channel B written this cycle |
| updBuf | output | 1 | Holding register written this cycle |
| updCtl | output | 1 | Control field written this cycle |

## Verification
Two functions can fall in the same cycle:
- A channel A write under target code 10, with the transfer of the old holding value into channel B.
- A channel B write under target code 00, with the load of the holding register.

Command sequences stage one value in the holding register and then issue a channel A write. The bench then checks that channel B holds the staged value and not the channel A payload. It also checks that both strobes rose in a single shared cycle and that exactly one strobe cycle occurred in the frame.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;

  // Strobes from the serial control to the latch datapath.
  typedef struct packed {
    logic frameStart;
    logic shiftEn;
    logic shiftBit;
    logic commit;
  } ser_strobe_t;

  // Target code formed from {word[MSB], word[MSB-3]}.
  typedef enum logic [1:0] {
    SEL_B_AND_BUF = 2'b00,
    SEL_BUF_ONLY  = 2'b01,
    SEL_A_XFER_B  = 2'b10,
    SEL_CONTROL   = 2'b11
  } tgt_sel_e;

endpackage

// File: rtl/dac_sync2.sv
`timescale 1ns/1ps
module dac_sync2 #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= asyncIn;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/dac_ser_ctrl.sv
`timescale 1ns/1ps
module dac_ser_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serSelN,
  input  logic        serData,
  output ser_strobe_t stb
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic clkS, selS, dataS;
  logic clkPrev, selPrev;
  logic active, done;
  logic [CNT_W-1:0] bitCnt;
  logic sclkFall, selFall, selRise, shiftNow, commitNow;

  dac_sync2 #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({serClk, serSelN, serData}),
    .syncOut({clkS, selS, dataS})
  );

  assign sclkFall = clkPrev & ~clkS;
  assign selFall  = selPrev & ~selS;
  assign selRise  = ~selPrev & selS;

  assign shiftNow  = active & ~done & ~selS & sclkFall & (bitCnt < FULL_CNT);
  assign commitNow = active & ~done &
                     ((bitCnt == FULL_CNT) | (selRise & (bitCnt != '0)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      selPrev <= 1'b1;
      active  <= 1'b0;
      done    <= 1'b0;
      bitCnt  <= '0;
    end else begin
      clkPrev <= clkS;
      selPrev <= selS;
      if (selFall) begin
        active <= 1'b1;
        done   <= 1'b0;
        bitCnt <= '0;
      end else begin
        if (commitNow) done <= 1'b1;
        if (selRise) active <= 1'b0;
        if (shiftNow) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.frameStart = selFall;
    stb.shiftEn    = shiftNow;
    stb.shiftBit   = dataS;
    stb.commit     = commitNow;
  end

endmodule

// File: rtl/dac_latch_path.sv
`timescale 1ns/1ps
module dac_latch_path
  import dac_cmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CODE_W = 8,
  parameter int REF_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ser_strobe_t       stb,
  output logic [CODE_W-1:0] chanA,
  output logic [CODE_W-1:0] chanB,
  output logic [CODE_W-1:0] holdBuf,
  output logic              fastMode,
  output logic              powerDown,
  output logic [REF_W-1:0]  refSel,
  output logic              updA,
  output logic              updB,
  output logic              updBuf,
  output logic              updCtl
);

  localparam int SEL_HI   = WORD_W - 1;
  localparam int SPD_POS  = WORD_W - 2;
  localparam int PWR_POS  = WORD_W - 3;
  localparam int SEL_LO   = WORD_W - 4;
  localparam int CODE_LSB = SEL_LO - CODE_W;

  logic [WORD_W-1:0] shReg;
  tgt_sel_e          selCode;
  logic [CODE_W-1:0] newCode;
  logic wrA, wrB, wrBuf, wrCtl;
  logic unusedPad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (stb.frameStart) shReg <= '0;
    else if (stb.shiftEn) shReg <= {shReg[WORD_W-2:0], stb.shiftBit};
  end

  assign selCode   = tgt_sel_e'({shReg[SEL_HI], shReg[SEL_LO]});
  assign newCode   = shReg[CODE_LSB +: CODE_W];
  assign unusedPad = ^shReg[CODE_LSB-1:REF_W];

  always_comb begin
    wrA = 1'b0; wrB = 1'b0; wrBuf = 1'b0; wrCtl = 1'b0;
    if (stb.commit) begin
      unique case (selCode)
        SEL_B_AND_BUF: begin wrB = 1'b1; wrBuf = 1'b1; end
        SEL_BUF_ONLY:  wrBuf = 1'b1;
        SEL_A_XFER_B:  begin wrA = 1'b1; wrB = 1'b1; end
        SEL_CONTROL:   wrCtl = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanA     <= '0;
      chanB     <= '0;
      holdBuf   <= '0;
      fastMode  <= 1'b0;
      powerDown <= 1'b0;
      refSel    <= '0;
      updA      <= 1'b0;
      updB      <= 1'b0;
      updBuf    <= 1'b0;
      updCtl    <= 1'b0;
    end else begin
      updA   <= wrA;
      updB   <= wrB;
      updBuf <= wrBuf;
      updCtl <= wrCtl;
      if (wrA) chanA <= newCode;
      if (wrB) chanB <= (selCode == SEL_A_XFER_B) ? holdBuf : newCode;
      if (wrBuf) holdBuf <= newCode;
      if (wrCtl) refSel <= shReg[REF_W-1:0];
      if (stb.commit) begin
        fastMode  <= shReg[SPD_POS];
        powerDown <= shReg[PWR_POS];
      end
    end
  end

endmodule

// File: rtl/dual_dac_cmd_dec.sv
`timescale 1ns/1ps
module dual_dac_cmd_dec
  import dac_cmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serSelN,
  input  logic              serData,
  output logic [CODE_W-1:0] chanA,
  output logic [CODE_W-1:0] chanB,
  output logic [CODE_W-1:0] holdBuf,
  output logic              fastMode,
  output logic              powerDown,
  output logic [1:0]        refSel,
  output logic              updA,
  output logic              updB,
  output logic              updBuf,
  output logic              updCtl
);

  ser_strobe_t stb;

  dac_ser_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serSelN(serSelN),
    .serData(serData), .stb(stb)
  );

  dac_latch_path #(.WORD_W(WORD_W), .CODE_W(CODE_W), .REF_W(2)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb),
    .chanA(chanA), .chanB(chanB), .holdBuf(holdBuf),
    .fastMode(fastMode), .powerDown(powerDown), .refSel(refSel),
    .updA(updA), .updB(updB), .updBuf(updBuf), .updCtl(updCtl)
  );

endmodule

// File: rtl/dual_dac_cmd_chk.sv
`timescale 1ns/1ps
module dual_dac_cmd_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] chanA,
  input logic [CODE_W-1:0] chanB,
  input logic [CODE_W-1:0] holdBuf,
  input logic              fastMode,
  input logic              powerDown,
  input logic [1:0]        refSel,
  input logic              updA,
  input logic              updB,
  input logic              updBuf,
  input logic              updCtl
);

  AST_CTL_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    updCtl |-> !(updA || updB || updBuf)); // R4

  AST_A_MOVES_BUF: assert property (@(posedge clk) disable iff (!rstN)
    updA |-> (updB && chanB == $past(holdBuf))); // R4

  AST_B_WITH_BUF: assert property (@(posedge clk) disable iff (!rstN)
    (updB && !updA) |-> (updBuf && chanB == holdBuf)); // R4

  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updA |-> $stable(chanA)); // R10

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updCtl |-> $stable(refSel)); // R10

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (updA || updB || updBuf || updCtl) |=> !(updA || updB || updBuf || updCtl)); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (chanA == '0 && chanB == '0 && holdBuf == '0 &&
                     !fastMode && !powerDown && refSel == 2'b00)); // R9

endmodule

bind dual_dac_cmd_dec dual_dac_cmd_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB), .holdBuf(holdBuf),
  .fastMode(fastMode), .powerDown(powerDown), .refSel(refSel),
  .updA(updA), .updB(updB), .updBuf(updBuf), .updCtl(updCtl)
);

// File: tb/dual_dac_cmd_dec_bench.sv
`timescale 1ns/1ps
module dual_dac_cmd_dec_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serSelN = 1'b1;
  logic serData = 1'b0;
  logic [7:0] chanA, chanB, holdBuf;
  logic fastMode, powerDown, updA, updB, updBuf, updCtl;
  logic [1:0] refSel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_cmd_dec u_dual_dac_cmd_dec (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serSelN(serSelN), .serData(serData),
    .chanA(chanA), .chanB(chanB), .holdBuf(holdBuf), .fastMode(fastMode),
    .powerDown(powerDown), .refSel(refSel), .updA(updA), .updB(updB),
    .updBuf(updBuf), .updCtl(updCtl)
  );

  // Strobe monitor: mask order {A, B, Buf, Ctl}.
  int strobeCycles = 0;
  logic [3:0] lastMask = '0;
  logic [7:0] aAtStrobe = '0;
  always @(negedge clk) begin
    if (updA || updB || updBuf || updCtl) begin
      strobeCycles <= strobeCycles + 1;
      lastMask <= {updA, updB, updBuf, updCtl};
      if (updA) aAtStrobe <= chanA;
    end
  end

  typedef struct packed {
    logic [15:0] word;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  hb;
    logic        f;
    logic        p;
    logic [1:0]  rs;
    logic [3:0]  mask;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'hD002, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 2'd2, 4'b0001},
    '{16'h1A50, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b0, 2'd2, 4'b0010},
    '{16'h8C3F, 8'hC3, 8'hA5, 8'hA5, 1'b0, 1'b0, 2'd2, 4'b1100},
    '{16'h477A, 8'hC3, 8'h77, 8'h77, 1'b1, 1'b0, 2'd2, 4'b0110},
    '{16'h3FFD, 8'hC3, 8'h77, 8'hFF, 1'b0, 1'b1, 2'd2, 4'b0010},
    '{16'hFFF1, 8'hC3, 8'h77, 8'hFF, 1'b1, 1'b1, 2'd1, 4'b0001},
    '{16'hA120, 8'h12, 8'hFF, 8'hFF, 1'b0, 1'b1, 2'd1, 4'b1100},
    '{16'h9000, 8'h12, 8'hFF, 8'hFF, 1'b0, 1'b0, 2'd0, 4'b0001}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] state();
    return {chanA, chanB, holdBuf, fastMode, powerDown, refSel};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [15:0] word, input int nBits, input int extra);
    serSelN = 1'b0;
    waitClk(6);
    for (int i = 0; i < nBits + extra; i++) begin
      serData = (i < nBits) ? word[15 - i] : 1'b1;
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
      waitClk(4);
    end
    waitClk(6);
    serSelN = 1'b1;
    waitClk(10);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [27:0] expState;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R9: reset state
    check(state() == '0 && !updA && !updB && !updBuf && !updCtl,
          "R9 reset state", 64'(state()), 64'd0);

    // Table walk: R1 R2 R4 R5 R6 R7 R10
    foreach (VECS[i]) begin
      base = strobeCycles;
      sendFrame(VECS[i].word, 16, 0);
      expState = {VECS[i].a, VECS[i].b, VECS[i].hb, VECS[i].f, VECS[i].p, VECS[i].rs};
      check(state() == expState, "R1 R2 R4 R5 R6 R7 vector state",
            64'(state()), 64'(expState));
      check(strobeCycles - base == 1 && lastMask == VECS[i].mask,
            "R4 R10 vector strobes", 64'({strobeCycles - base, lastMask}),
            64'({32'd1, VECS[i].mask}));
      if (VECS[i].mask[3])
        check(aAtStrobe == VECS[i].a, "R10 value with strobe",
              64'(aAtStrobe), 64'(VECS[i].a));
    end

    // R8: extra clock edges after the 16th bit
    base = strobeCycles;
    sendFrame(16'h0340, 16, 4);
    expState = {8'h12, 8'h34, 8'h34, 1'b0, 1'b0, 2'd0};
    check(state() == expState, "R8 extra edges state", 64'(state()), 64'(expState));
    check(strobeCycles - base == 1 && lastMask == 4'b0110, "R8 single commit",
          64'(strobeCycles - base), 64'd1);

    // R11 and R3: edges with select high, then an empty frame
    base = strobeCycles;
    for (int i = 0; i < 16; i++) begin
      serData = 1'b1;
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
      waitClk(4);
    end
    sendFrame(16'hFFFF, 0, 0);
    check(state() == expState, "R11 idle edges ignored", 64'(state()), 64'(expState));
    check(strobeCycles == base, "R3 empty frame no commit",
          64'(strobeCycles - base), 64'd0);

    // R3: early select rise after 12 bits -> word 0x0D5A
    base = strobeCycles;
    sendFrame(16'hD5A7, 12, 0);
    expState = {8'h12, 8'hD5, 8'hD5, 1'b0, 1'b0, 2'd0};
    check(state() == expState, "R3 partial frame", 64'(state()), 64'(expState));
    check(strobeCycles - base == 1 && lastMask == 4'b0110, "R3 partial strobes",
          64'(lastMask), 64'(4'b0110));

    // R9: reset after activity
    sendFrame(16'hF003, 16, 0);
    waitClk(2);
    rstN = 1'b0;
    waitClk(3);
    check(state() == '0, "R9 reset clears", 64'(state()), 64'd0);
    rstN = 1'b1;
    waitClk(3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule